// File: doc/BRIEF.md
# Oscillator Stabilization Wait Counter

This block runs on the crystal oscillator clock and counts the cycles that pass after the oscillator has been (re)started, or after a low-power stop period has ended. Elapsed time appears on an 8-bit read-only status byte. That byte fills as a thermometer code from the most significant bit down. Each bit stands for a power-of-two cycle threshold, and the spacing of those thresholds is not uniform.

A 3-bit select input sets how long the wait lasts. When the count reaches the selected limit, the counter freezes and a done flag goes high. Status bits whose thresholds lie above the limit therefore stay at zero.

The wait restarts in two cases: when the restart input is pulsed, and while the stop-mode indication is high. Cycles spent in stop mode are not counted. A `SCALE_DOWN` parameter divides every threshold by 2^SCALE_DOWN so that shortened configurations can be built. The default value 0 gives the full-length thresholds.

Top module: `osw_stab_wait`

## Requirements
- R1: While reset is low, and after reset is released, `stab_status` is 0x00 and `stab_done` is 0.
- R2: `stab_status` only ever holds one of 00, 80, C0, E0, F0, F8, FC, FE or FF (hex). Bits fill from bit 7 downward.
- R3: Bits 7 down to 0 correspond to elapsed-cycle thresholds of 2^8, 2^9, 2^10, 2^11, 2^13, 2^15, 2^17 and 2^18 (each divided by 2^SCALE_DOWN). A bit reads 1 once the count since the last clear is at least its threshold.
- R4: A status bit that is 1 stays 1 until the next restart, stop-mode cycle or reset.
- R5: `wait_sel` values 0 to 7 select limits equal to the thresholds of bits 7 down to 0, in that order. Counting halts at the limit, so the bits for larger thresholds remain 0 and the status no longer changes.
- R6: `stab_done` goes high in the same cycle in which the count reaches the selected limit. It stays high until the next restart, stop-mode cycle or reset, even if `wait_sel` is later raised.
- R7: A clock edge that samples `restart` high clears the count, the status and the done flag. Counting resumes from zero on the following edge.
- R8: While `stop_mode` is high, the count, status and done flag are held at zero. Counting starts from zero once it falls.
- R9: If `wait_sel` is lowered to a limit that the count has already passed, `stab_done` rises at once without waiting for a clock edge. The count and status then freeze.
- R10: With `SCALE_DOWN` = S, every threshold and limit becomes 2^(e-S), where e is its unscaled exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock being counted |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Single-cycle request to restart the wait |
| stop_mode | input | 1 | High while the chip is in low-power stop |
| wait_sel | input | 3 | Selects the wait limit (0 shortest, 7 longest) |
| stab_status | output | 8 | Thermometer-coded elapsed-time status |
| stab_done | output | 1 | Wait limit reached |

## Verification
On every cycle, the assertions check the following: the status code is always a legal thermometer value, set bits stay set, both outputs freeze once done is high, a restart or stop cycle clears both outputs, and reset forces the idle state. Other behaviours can only be shown by the bench's scenarios. These are the exact cycle at which each threshold bit appears, the mapping of select codes to limits, the immediate done when the select is lowered below the elapsed count, and done staying high after the select is raised again.

// File: rtl/osw_pkg.sv
package osw_pkg;
   localparam int OSW_TAPS    = 8;
   localparam int OSW_MAX_EXP = 18;
   localparam int OSW_SEL_W   = $clog2(OSW_TAPS);

   // tap index 0 is the shortest threshold (status bit 7)
   function automatic int tap_exp(input int idx);
      case (idx)
         0:       return 8;
         1:       return 9;
         2:       return 10;
         3:       return 11;
         4:       return 13;
         5:       return 15;
         6:       return 17;
         default: return 18;
      endcase
   endfunction
endpackage

// File: rtl/osw_tap_table.sv
module osw_tap_table
   import osw_pkg::*;
#(
   parameter int SCALE_DOWN = 0,
   parameter int CNT_W      = OSW_MAX_EXP + 1
) (
   output logic [OSW_TAPS-1:0][CNT_W-1:0] thr
);
   for (genvar g = 0; g < OSW_TAPS; g++) begin : g_tap
      localparam int SH = tap_exp(g) - SCALE_DOWN;
      assign thr[g] = {{(CNT_W-1){1'b0}}, 1'b1} << SH;
   end
endmodule

// File: rtl/osw_sat_counter.sv
module osw_sat_counter #(
   parameter int CNT_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (en)    cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/osw_thermo.sv
module osw_thermo
   import osw_pkg::*;
#(
   parameter int CNT_W = 19
) (
   input  logic [CNT_W-1:0]               cnt,
   input  logic [OSW_TAPS-1:0][CNT_W-1:0] thr,
   output logic [OSW_TAPS-1:0]            status
);
   // shortest threshold drives the MSB
   for (genvar g = 0; g < OSW_TAPS; g++) begin : g_cmp
      assign status[OSW_TAPS-1-g] = (cnt >= thr[g]);
   end
endmodule

// File: rtl/osw_stab_wait.sv
module osw_stab_wait
   import osw_pkg::*;
#(
   parameter int SCALE_DOWN = 0
) (
   input  logic       clk_osc,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       stop_mode,
   input  logic [2:0] wait_sel,
   output logic [7:0] stab_status,
   output logic       stab_done
);
   localparam int CNT_W = OSW_MAX_EXP - SCALE_DOWN + 1;

   if (SCALE_DOWN < 0 || SCALE_DOWN > 8) begin : g_bad_scale
      $error("SCALE_DOWN must lie in 0..8");
   end
   if (OSW_SEL_W != 3) begin : g_bad_sel
      $error("select width must be 3");
   end

   logic [OSW_TAPS-1:0][CNT_W-1:0] thr;
   logic [CNT_W-1:0]               cnt;
   logic [CNT_W-1:0]               limit;
   logic                           clr;
   logic                           done_q;
   logic                           reach;

   assign clr   = restart | stop_mode;
   assign limit = thr[wait_sel];
   assign reach = (cnt >= limit);

   osw_tap_table #(.SCALE_DOWN(SCALE_DOWN), .CNT_W(CNT_W)) u_tab (
      .thr (thr)
   );

   osw_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk_osc),
      .rst_n (rst_n),
      .clear (clr),
      .en    (!stab_done),
      .cnt   (cnt)
   );

   osw_thermo #(.CNT_W(CNT_W)) u_therm (
      .cnt    (cnt),
      .thr    (thr),
      .status (stab_status)
   );

   // done holds once reached, independent of later select changes
   always_ff @(posedge clk_osc or negedge rst_n) begin
      if (!rst_n)   done_q <= 1'b0;
      else if (clr) done_q <= 1'b0;
      else          done_q <= stab_done;
   end

   assign stab_done = done_q | reach;
endmodule

// File: rtl/osw_stab_wait_chk.sv
module osw_stab_wait_chk (
   input logic       clk_osc,
   input logic       rst_n,
   input logic       restart,
   input logic       stop_mode,
   input logic [7:0] stab_status,
   input logic       stab_done
);
   // R1
   p_reset_idle_r1: assert property (@(posedge clk_osc)
      !rst_n |-> (stab_status == 8'h00 && !stab_done));

   // R2
   p_legal_code_r2: assert property (@(posedge clk_osc) disable iff (!rst_n)
      ((stab_status << 1) & ~stab_status) == 8'h00);

   // R4
   p_sticky_bits_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (!restart && !stop_mode) |=>
         ((stab_status & $past(stab_status)) == $past(stab_status)));

   // R5
   p_frozen_at_limit_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (stab_done && !restart && !stop_mode) |=> $stable(stab_status));

   // R6
   p_done_holds_r6: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (stab_done && !restart && !stop_mode) |=> stab_done);

   // R7 and R8
   p_clear_r7_r8: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (restart || stop_mode) |=> (stab_status == 8'h00 && !stab_done));
endmodule

bind osw_stab_wait osw_stab_wait_chk u_chk (
   .clk_osc     (clk_osc),
   .rst_n       (rst_n),
   .restart     (restart),
   .stop_mode   (stop_mode),
   .stab_status (stab_status),
   .stab_done   (stab_done)
);

// File: tb/test_osw_stab_wait.sv
`timescale 1ns/1ps
module test_osw_stab_wait;
   // SCALE_DOWN=6: thresholds 4,8,16,32,128,512,2048,4096 (R10)
   localparam int SD = 6;

   logic       clk_osc = 1'b0;
   logic       rst_n = 1'b0;
   logic       restart = 1'b0;
   logic       stop_mode = 1'b0;
   logic [2:0] wait_sel = 3'd0;
   logic [7:0] stab_status;
   logic       stab_done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 clk_osc = ~clk_osc;

   osw_stab_wait #(.SCALE_DOWN(SD)) i_osw_stab_wait (
      .clk_osc     (clk_osc),
      .rst_n       (rst_n),
      .restart     (restart),
      .stop_mode   (stop_mode),
      .wait_sel    (wait_sel),
      .stab_status (stab_status),
      .stab_done   (stab_done)
   );

   // {sel[3:0], cycles[15:0], status[7:0], done[3:0]}
   localparam logic [31:0] VEC [15] = '{
      {4'd0, 16'd3,    8'h00, 4'd0},
      {4'd0, 16'd4,    8'h80, 4'd1},
      {4'd0, 16'd50,   8'h80, 4'd1},
      {4'd1, 16'd7,    8'h80, 4'd0},
      {4'd1, 16'd8,    8'hC0, 4'd1},
      {4'd2, 16'd20,   8'hE0, 4'd1},
      {4'd3, 16'd31,   8'hE0, 4'd0},
      {4'd3, 16'd32,   8'hF0, 4'd1},
      {4'd4, 16'd127,  8'hF0, 4'd0},
      {4'd4, 16'd200,  8'hF8, 4'd1},
      {4'd5, 16'd600,  8'hFC, 4'd1},
      {4'd6, 16'd2047, 8'hFC, 4'd0},
      {4'd6, 16'd2048, 8'hFE, 4'd1},
      {4'd7, 16'd4095, 8'hFE, 4'd0},
      {4'd7, 16'd5000, 8'hFF, 4'd1}
   };

   task automatic check(input string req, input logic [7:0] exp_st, input logic exp_dn);
      n_chk++;
      if (stab_status !== exp_st || stab_done !== exp_dn) begin
         n_bad++;
         $display("FAIL %s: status=%h done=%b, expected status=%h done=%b",
                  req, stab_status, stab_done, exp_st, exp_dn);
      end
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk_osc);
      @(negedge clk_osc);
   endtask

   task automatic pulse_restart();
      @(negedge clk_osc);
      restart = 1'b1;
      @(negedge clk_osc);
      restart = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #5;
      check("R1 in reset", 8'h00, 1'b0);
      @(negedge clk_osc);
      @(negedge clk_osc);
      rst_n = 1'b1;
      check("R1 after reset", 8'h00, 1'b0);

      // R3 R5 R6 R10 vector walk
      for (int i = 0; i < 15; i++) begin
         wait_sel = VEC[i][30:28];
         pulse_restart();
         run(int'(VEC[i][27:12]));
         check($sformatf("R3 R5 R6 R10 vec %0d", i), VEC[i][11:4], VEC[i][0]);
      end

      // R7: restart clears mid-run
      wait_sel = 3'd7;
      pulse_restart();
      run(40);
      check("R3 sel7 40 cycles", 8'hF0, 1'b0);
      pulse_restart();
      check("R7 restart clears", 8'h00, 1'b0);
      run(4);
      check("R7 counts from zero", 8'h80, 1'b0);

      // R8: stop mode holds at zero
      run(40);
      stop_mode = 1'b1;
      run(10);
      check("R8 held in stop", 8'h00, 1'b0);
      @(negedge clk_osc);
      stop_mode = 1'b0;
      run(7);
      check("R8 seven after stop", 8'h80, 1'b0);
      run(1);
      check("R8 eight after stop", 8'hC0, 1'b0);

      // R9: lowering select below elapsed count
      pulse_restart();
      run(100);
      check("R9 before select drop", 8'hF0, 1'b0);
      wait_sel = 3'd2;
      #1;
      check("R9 immediate done", 8'hF0, 1'b1);
      run(20);
      check("R4 R9 frozen after drop", 8'hF0, 1'b1);
      // R6: raising select keeps done
      wait_sel = 3'd7;
      #1;
      check("R6 done holds on raise", 8'hF0, 1'b1);
      run(300);
      check("R5 R6 still frozen", 8'hF0, 1'b1);

      // R1: async reset mid-run
      #3 rst_n = 1'b0;
      #1;
      check("R1 async reset", 8'h00, 1'b0);
      @(negedge clk_osc);
      rst_n = 1'b1;
      wait_sel = 3'd0;
      run(4);
      check("R1 R3 count after reset", 8'h80, 1'b1);

      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk_osc);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end
endmodule